// File: doc/BRIEF.md
# Masked Pseudo-Random Offset Generator

This block adds a pseudo-random dither offset to the held sample of one converter channel. A 12-bit linear feedback shift register supplies the noise. A 4-bit amplitude code selects how many of its low bits reach the adder. The masked noise is summed with a 12-bit base word, and the sum clamps at full scale instead of wrapping. The shift register advances once for every trigger strobe that arrives while the channel is in noise mode. The result is a fresh output word each time a timer or other event fires the channel.

Each strobe passes through a fixed three-cycle delay. When the delayed strobe is seen, the adder uses the current register value and the register then steps. Leaving noise mode by writing the mode field to zero puts the register back at its seed. The amplitude code can only be changed while the channel enable is low.

Top module: `noise_offset_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `out_word` becomes 0x000 and `lfsr_state` becomes 0xAAA.
- R2: A `wave_sel` value of 2'b01 selects noise. A `wave_sel` value of 2'b00 at a clock edge sets `lfsr_state` to 0xAAA.
- R3: One noise step moves every bit of the register one place toward bit 0. The new bit 11 is the XOR of the old bits 0, 1, 4 and 6. Starting from 0xAAA, the next value is 0xD55.
- R4: With base 0 and amplitude code 15, the first two noise triggers after the seed give `out_word` values 0xAAA and then 0xD55.
- R5: A trigger sampled high at edge k updates `out_word` and `lfsr_state` at edge k+3 and at no earlier edge. The output uses the register value from before the step.
- R6: An amplitude code n from 0 to 10 keeps register bits [n:0] and zeroes the others. Codes 11 to 15 keep all 12 bits.
- R7: The output is base plus masked noise, limited to 0xFFF. It never wraps below the base.
- R8: The amplitude code is captured at edges where `chan_en` is low. Changes made while `chan_en` is high have no effect on the mask.
- R9: A delayed trigger in any mode other than 2'b01 loads the base unchanged into `out_word`. In modes 2'b10 and 2'b11 it leaves `lfsr_state` unchanged.
- R10: Triggers on consecutive cycles each produce their own update, one per cycle, three cycles later.
- R11: `lfsr_state` is never all zeros. If it ever were, the feedback bit is forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; the amplitude code is captured only while this is low |
| wave_sel | input | 2 | Wave mode: 00 off, 01 noise, 1x other (pass base through) |
| amp_code | input | 4 | Amplitude or mask code |
| base_val | input | 12 | Held base sample |
| trig_in | input | 1 | Trigger strobe, one per conversion |
| out_word | output | 12 | Base plus masked noise, clamped |
| lfsr_state | output | 12 | Current shift register contents |

## Verification
The assertions check several properties on every cycle. The reset values must hold, and the output must stay stable whenever no delayed trigger is present. Each noise step must be a one-place shift toward bit 0. The register must never be zero, the clamped sum must never fall below the base, and the latched amplitude code must stay frozen while the channel is enabled. Some behaviours can only be shown by the bench's scenarios. These are the exact feedback values, the mask width for each of the sixteen codes, the three-cycle latency measured from the port, and the seed restore on mode 00. They also include the ignored code write and a long run of back-to-back triggers compared against an arithmetic model.

// File: rtl/noise_gen_pkg.sv
package noise_gen_pkg;

    localparam int NG_W      = 12;
    localparam int NG_CODE_W = 4;
    localparam int NG_LAT    = 3;
    localparam logic [NG_W-1:0] NG_SEED = 12'hAAA;
    // feedback taps: bits 0, 1, 4 and 6
    localparam logic [NG_W-1:0] NG_TAPS = 12'h053;

    typedef logic [NG_W-1:0]      word_t;
    typedef logic [NG_CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        WAVE_OFF   = 2'b00,
        WAVE_NOISE = 2'b01,
        WAVE_TRI_A = 2'b10,
        WAVE_TRI_B = 2'b11
    } wave_e;

    typedef struct packed {
        logic  ovf;
        word_t val;
    } sum_t;

    // one step: shift toward bit 0, feedback into the top bit,
    // a forced 1 if the register is empty
    function automatic word_t lfsr_next(input word_t s);
        logic fb;
        fb = ^(s & NG_TAPS);
        if (s == '0) fb = 1'b1;
        return {fb, s[NG_W-1:1]};
    endfunction

    // code n keeps bits [n:0]; codes at or above NG_W-1 keep everything
    function automatic word_t code_to_mask(input code_t c);
        word_t m;
        for (int i = 0; i < NG_W; i++) begin
            m[i] = (i <= int'(c));
        end
        return m;
    endfunction

    function automatic word_t sat_add(input word_t a, input word_t b);
        sum_t s;
        s = sum_t'({1'b0, a} + {1'b0, b});
        return s.ovf ? '1 : s.val;
    endfunction

endpackage

// File: rtl/ng_trig_pipe.sv
module ng_trig_pipe #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic fire
);
    generate
        if (LAT == 0) begin : g_direct
            assign fire = trig;
        end else begin : g_delay
            logic [LAT-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q <= '0;
                end else if (LAT == 1) begin
                    stage_q <= trig;
                end else begin
                    stage_q <= {stage_q[LAT-2:0], trig} & {LAT{1'b1}};
                end
            end
            assign fire = stage_q[LAT-1];

            // R1: the delay line is empty after reset
            a_r1_pipe_empty: assert property (@(posedge clk)
                rst |=> (fire == 1'b0));
        end
    endgenerate
endmodule

// File: rtl/ng_amp_latch.sv
module ng_amp_latch
    import noise_gen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  chan_en,
    input  code_t code_in,
    output word_t mask
);
    code_t amp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_q <= '0;
        end else if (!chan_en) begin
            amp_q <= code_in;
        end
    end

    assign mask = code_to_mask(amp_q);

    // R8: the captured code cannot move while the channel is enabled
    a_r8_code_frozen: assert property (@(posedge clk) disable iff (rst)
        chan_en |=> $stable(amp_q));

    // R6: the mask is always a run of ones starting at bit 0
    a_r6_mask_shape: assert property (@(posedge clk) disable iff (rst)
        (mask[0] == 1'b1) && ((mask & (mask + 1'b1)) == '0));
endmodule

// File: rtl/ng_lfsr.sv
module ng_lfsr
    import noise_gen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  adv,
    output word_t state
);
    word_t st_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st_q <= NG_SEED;
        end else if (adv) begin
            st_q <= lfsr_next(st_q);
        end
    end

    assign state = st_q;

    // R1: seed after reset
    a_r1_seed_on_reset: assert property (@(posedge clk)
        rst |=> (state == NG_SEED));

    // R2: mode off restores the seed
    a_r2_clear_seed: assert property (@(posedge clk) disable iff (rst)
        clear |=> (state == NG_SEED));

    // R3: a step is a one-place move toward bit 0
    a_r3_shift_down: assert property (@(posedge clk) disable iff (rst)
        (adv && !clear) |=> (state[NG_W-2:0] == $past(state[NG_W-1:1])));

    // R11: the register never holds all zeros
    a_r11_never_zero: assert property (@(posedge clk) disable iff (rst)
        state != '0);
endmodule

// File: rtl/noise_offset_gen.sv
module noise_offset_gen
    import noise_gen_pkg::*;
#(
    parameter int W      = NG_W,
    parameter int CODE_W = NG_CODE_W,
    parameter int LAT    = NG_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic [1:0]        wave_sel,
    input  logic [CODE_W-1:0] amp_code,
    input  logic [W-1:0]      base_val,
    input  logic              trig_in,
    output logic [W-1:0]      out_word,
    output logic [W-1:0]      lfsr_state
);
    wave_e mode;
    logic  fire;
    logic  is_noise;
    logic  is_off;
    word_t mask;
    word_t noise;
    word_t out_q;

    assign mode     = wave_e'(wave_sel);
    assign is_noise = (mode == WAVE_NOISE);
    assign is_off   = (mode == WAVE_OFF);

    ng_trig_pipe #(.LAT(LAT)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .trig (trig_in),
        .fire (fire)
    );

    ng_amp_latch u_amp (
        .clk     (clk),
        .rst     (rst),
        .chan_en (chan_en),
        .code_in (amp_code),
        .mask    (mask)
    );

    ng_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .clear (is_off),
        .adv   (fire && is_noise),
        .state (noise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (fire) begin
            out_q <= is_noise ? sat_add(base_val, noise & mask) : base_val;
        end
    end

    assign out_word   = out_q;
    assign lfsr_state = noise;

    // R1: output cleared by reset
    a_r1_out_reset: assert property (@(posedge clk)
        rst |=> (out_word == '0));

    // R5: without a delayed trigger the output holds
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(out_word));

    // R7: the clamped sum never falls below the base
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        fire |=> (out_word >= $past(base_val)));

    // R9: outside noise mode the base passes untouched
    a_r9_plain_base: assert property (@(posedge clk) disable iff (rst)
        (fire && !is_noise) |=> (out_word == $past(base_val)));

    // R9: non-noise triggers leave the register alone
    a_r9_lfsr_kept: assert property (@(posedge clk) disable iff (rst)
        (!is_noise && !is_off) |=> $stable(lfsr_state));
endmodule

// File: tb/sim_noise_offset_gen.sv
module sim_noise_offset_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic [1:0]  wave_sel = 2'b00;
    logic [3:0]  amp_code = 4'd0;
    logic [11:0] base_val = 12'd0;
    logic        trig_in = 1'b0;
    logic [11:0] out_word;
    logic [11:0] lfsr_state;

    int total = 0;
    int bad   = 0;
    logic [11:0] m_lfsr;

    always #4 clk = ~clk;

    noise_offset_gen u0 (
        .clk(clk), .rst(rst), .chan_en(chan_en), .wave_sel(wave_sel),
        .amp_code(amp_code), .base_val(base_val), .trig_in(trig_in),
        .out_word(out_word), .lfsr_state(lfsr_state)
    );

    function automatic logic [11:0] m_step(input logic [11:0] s);
        logic fb;
        fb = s[0] ^ s[1] ^ s[4] ^ s[6];
        if (s == 12'd0) fb = 1'b1;
        return {fb, s[11:1]};
    endfunction

    function automatic logic [11:0] m_mask(input int c);
        if (c >= 11) return 12'hFFF;
        return 12'((1 << (c + 1)) - 1);
    endfunction

    function automatic logic [11:0] m_sat(input logic [11:0] b, input logic [11:0] n);
        int s;
        s = int'(b) + int'(n);
        return (s > 4095) ? 12'hFFF : 12'(s);
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_code(input int c);
        @(negedge clk);
        chan_en  = 1'b0;
        amp_code = 4'(c);
        @(negedge clk);
        chan_en  = 1'b1;
    endtask

    // one trigger; returns just after the edge where it takes effect
    task automatic pulse();
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // noise trigger with model update and checks
    task automatic noise_shot(input string req, input int c);
        logic [11:0] eo;
        eo = m_sat(base_val, m_lfsr & m_mask(c));
        m_lfsr = m_step(m_lfsr);
        pulse();
        chk(req, out_word, eo);
        chk(req, lfsr_state, m_lfsr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out", out_word, 12'h000);
        chk("R1 lfsr", lfsr_state, 12'hAAA);
        rst = 1'b0;
        wave_sel = 2'b01;
        m_lfsr = 12'hAAA;
        set_code(15);

        // R5 latency, R4 and R3 first values
        @(negedge clk);
        base_val = 12'h000;
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        @(negedge clk);
        chk("R5 early1", out_word, 12'h000);
        @(negedge clk);
        chk("R5 early2", out_word, 12'h000);
        chk("R5 lfsr early", lfsr_state, 12'hAAA);
        @(negedge clk);
        chk("R4 first", out_word, 12'hAAA);
        chk("R3 step", lfsr_state, 12'hD55);
        m_lfsr = 12'hD55;
        noise_shot("R4 second", 15);
        chk("R4 second value", out_word, 12'hD55);

        // R2 mode off restores the seed
        @(negedge clk);
        wave_sel = 2'b00;
        @(negedge clk);
        chk("R2 seed restore", lfsr_state, 12'hAAA);
        wave_sel = 2'b01;
        m_lfsr = 12'hAAA;

        // R6 / R7 sweep over every code and several bases
        for (int c = 0; c < 16; c++) begin
            set_code(c);
            for (int i = 0; i < 6; i++) begin
                base_val = 12'((i * 16'h2B7 + c * 16'h1F3) & 16'hFFF);
                noise_shot("R6 R7 sweep", c);
            end
        end

        // R7 clamp at full scale
        base_val = 12'hFFF;
        noise_shot("R7 clamp full", 15);
        chk("R7 clamp value", out_word, 12'hFFF);
        base_val = 12'hF80;
        noise_shot("R7 clamp high", 11);

        // R8 code change while enabled is ignored
        set_code(2);
        @(negedge clk);
        amp_code = 4'd15;
        base_val = 12'h010;
        noise_shot("R8 code ignored", 2);

        // R9 other modes pass base, keep register
        @(negedge clk);
        wave_sel = 2'b10;
        base_val = 12'h123;
        pulse();
        chk("R9 tri base", out_word, 12'h123);
        chk("R9 tri lfsr", lfsr_state, m_lfsr);
        wave_sel = 2'b11;
        base_val = 12'h321;
        pulse();
        chk("R9 tri2 base", out_word, 12'h321);
        chk("R9 tri2 lfsr", lfsr_state, m_lfsr);
        wave_sel = 2'b00;
        base_val = 12'h456;
        pulse();
        chk("R9 off base", out_word, 12'h456);
        chk("R2 off lfsr", lfsr_state, 12'hAAA);
        m_lfsr = 12'hAAA;
        wave_sel = 2'b01;

        // R10 / R11 back-to-back triggers, one update per cycle
        set_code(15);
        base_val = 12'h100;
        @(negedge clk);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        for (int j = 0; j < 4200; j++) begin
            logic [11:0] eo;
            @(negedge clk);
            eo = m_sat(base_val, m_lfsr);
            m_lfsr = m_step(m_lfsr);
            chk("R10 burst out", out_word, eo);
            chk("R10 burst lfsr", lfsr_state, m_lfsr);
            total++;
            if (lfsr_state == 12'h000) begin
                bad++;
                $display("FAIL R11 actual=%h expected=nonzero", lfsr_state);
            end
        end
        trig_in = 1'b0;
        repeat (4) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule